// File: doc/BRIEF.md
# Flash Status Toggle Bit Generator

This block is the status side of a parallel NOR flash model. While an embedded program or erase runs, a read of the part does not return stored data. It returns a status word with three live bits: a global toggle bit, a timeout flag and a sector toggle bit. Stub inputs stand in for the embedded algorithm. They report busy, erase-in-progress, erase-suspend and timeout. Two per-sector masks give the sectors picked for erase and the sectors that are write protected.

A read access opens when both the chip-select and output-enable strobes are low, after at least one of them was high. Each access may invert the toggle bits. The global bit inverts while the device is working. The sector bit inverts only when the address hits a sector marked for erase. When a program is aimed at a protected sector, a short status window is produced that ends by itself after a set number of cycles. The block also applies the program masking rule to write data, so programming can only clear bits.

The sector of an address is taken from its top bits. With the default parameters the sector is `addr[7:6]`.

Top module: `nor_status_gen`

## Requirements
- R1: When no status source is active (busy, erase-suspend-read of a selected sector, protection window, timeout flag), `dout` equals `arr_rdata` while `ce_n` and `oe_n` are both low. It is all zeros whenever either strobe is high.
- R2: The status word puts the global toggle bit at bit 6, the timeout flag at bit 5 and the sector toggle bit at bit 2. All other bits are 0.
- R3: While `busy` is high, bit 6 inverts once per read access. A new access needs `ce_n` or `oe_n` to go high and then both to be low again. Holding the strobes low gives no further inversion.
- R4: `op_start` clears both toggle bits to 0. A read access that opens in the same cycle counts as the first read of the new operation, so it shows bit 6 = 1.
- R5: With `ers_susp` high and `busy` low, bit 6 holds its value. Reads of erase-selected sectors return the status word. Reads of other sectors return array data.
- R6: During a program inside an erase suspend (`busy` and `ers_susp` both high), bit 6 inverts on each access again. It freezes once `busy` falls.
- R7: Bit 2 inverts on a read access only when `ers_op` is high and the address lies in a sector whose `ers_sel` bit is set. This applies to both active and suspended erase. Otherwise bit 2 keeps its value.
- R8: An `op_start` with `op_prog` high and `op_addr` in a protected sector gives a status window of PROT_CYC cycles in which bit 6 inverts per access. After the window, reads return array data.
- R9: A `timeout` pulse sets bit 5. The flag stays set, keeps the status word on the bus and keeps bit 6 inverting until a `reset_cmd`. A `timeout` and a `reset_cmd` in the same cycle leave the flag set.
- R10: `wr_data` equals `wr_old & wr_new`. A request to turn a 0 into a 1 is dropped and does not set bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| op_start | input | 1 | pulse at the last write strobe of a command sequence |
| op_prog | input | 1 | the started operation is a program |
| op_addr | input | ADDR_W | target address of the started operation |
| busy | input | 1 | embedded algorithm running |
| ers_op | input | 1 | erase in progress or suspended |
| ers_susp | input | 1 | erase is suspended |
| timeout | input | 1 | pulse-count limit exceeded |
| reset_cmd | input | 1 | reset command decoded |
| ers_sel | input | NSECT | sectors selected for erase |
| prot | input | NSECT | write-protected sectors |
| rd_addr | input | ADDR_W | read address |
| ce_n | input | 1 | chip select, active low |
| oe_n | input | 1 | output enable, active low |
| arr_rdata | input | DATA_W | array read data |
| dout | output | DATA_W | data bus value |
| wr_old | input | DATA_W | stored word at the program address |
| wr_new | input | DATA_W | requested program data |
| wr_data | output | DATA_W | masked word to store |

## Verification
Two pairs of functions can land on the same clock edge. The first is a new operation starting while a read access opens. The bench drives `op_start` low-to-high together with both strobes low, at an erase-selected address. It expects 0x44: both toggle bits are cleared and then inverted once. The second is a `timeout` pulse arriving with a `reset_cmd`. The bench pulses both together and expects the next access to show bit 5 still set, with bit 6 inverted from its prior value.

// File: rtl/nor_stat_pkg.sv
package nor_stat_pkg;
  // bit positions inside the status word
  localparam int B_TOG = 6;
  localparam int B_TMO = 5;
  localparam int B_SEC = 2;

  typedef enum logic [1:0] {
    SRC_IDLE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } bus_src_e;
endpackage

// File: rtl/nor_rd_edge.sv
module nor_rd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic rd_act,
  output logic rd_start
);
  logic rd_act_q;

  assign rd_act   = ~ce_n & ~oe_n;
  assign rd_start = rd_act & ~rd_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_act_q <= 1'b0;
    else        rd_act_q <= rd_act;
  end
endmodule

// File: rtl/nor_prot_timer.sv
module nor_prot_timer #(
  parameter int PROT_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic win_on
);
  localparam int CW = $clog2(PROT_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= CW'(PROT_CYC);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign win_on = (cnt != '0);
endmodule

// File: rtl/nor_toggle_core.sv
module nor_toggle_core (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic tog6,
  input  logic tog2,
  input  logic timeout,
  input  logic reset_cmd,
  output logic t6,
  output logic t2,
  output logic to_flag
);
  // a new operation clears the base value, a read in the same cycle then flips it
  function automatic logic next_bit(input logic cur, input logic clr, input logic flip);
    return (clr ? 1'b0 : cur) ^ flip;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6      <= 1'b0;
      t2      <= 1'b0;
      to_flag <= 1'b0;
    end else begin
      t6 <= next_bit(t6, op_start, tog6);
      t2 <= next_bit(t2, op_start, tog2);
      if (timeout)        to_flag <= 1'b1;
      else if (reset_cmd) to_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/nor_status_gen.sv
module nor_status_gen
  import nor_stat_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NSECT    = 4,
  parameter int PROT_CYC = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              op_prog,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              busy,
  input  logic              ers_op,
  input  logic              ers_susp,
  input  logic              timeout,
  input  logic              reset_cmd,
  input  logic [NSECT-1:0]  ers_sel,
  input  logic [NSECT-1:0]  prot,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dout,
  input  logic [DATA_W-1:0] wr_old,
  input  logic [DATA_W-1:0] wr_new,
  output logic [DATA_W-1:0] wr_data
);
  localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1;
  localparam int SH     = ADDR_W - SECT_W;

  // true when the sector of address a has its bit set in mask
  function automatic logic sect_hit(input logic [NSECT-1:0] mask, input logic [ADDR_W-1:0] a);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NSECT; i++)
      if (mask[i] && ((a >> SH) == ADDR_W'(i))) r = 1'b1;
    return r;
  endfunction

  // programming can only clear bits
  function automatic logic [DATA_W-1:0] prog_mask(input logic [DATA_W-1:0] o, input logic [DATA_W-1:0] n);
    return o & n;
  endfunction

  function automatic logic [DATA_W-1:0] stat_word(input logic b6, input logic b5, input logic b2);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[B_TOG] = b6;
    w[B_TMO] = b5;
    w[B_SEC] = b2;
    return w;
  endfunction

  // named internal events
  logic     rd_act, rd_start;
  logic     sel_hit, prot_load, prot_on;
  logic     tog6_en, tog6, tog2;
  logic     t6, t2, to_flag;
  logic     stat_on;
  bus_src_e src;

  nor_rd_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .rd_act   (rd_act),
    .rd_start (rd_start)
  );

  assign prot_load = op_start & op_prog & sect_hit(prot, op_addr);

  nor_prot_timer #(.PROT_CYC(PROT_CYC)) u_ptmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (prot_load),
    .win_on (prot_on)
  );

  assign sel_hit = sect_hit(ers_sel, rd_addr);
  assign tog6_en = busy | prot_on | to_flag;
  assign tog6    = rd_start & tog6_en;
  assign tog2    = rd_start & ers_op & sel_hit;

  nor_toggle_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_start  (op_start),
    .tog6      (tog6),
    .tog2      (tog2),
    .timeout   (timeout),
    .reset_cmd (reset_cmd),
    .t6        (t6),
    .t2        (t2),
    .to_flag   (to_flag)
  );

  assign stat_on = tog6_en | (ers_susp & ers_op & sel_hit);

  always_comb begin
    if (!rd_act)      src = SRC_IDLE;
    else if (stat_on) src = SRC_STATUS;
    else              src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_STATUS: dout = stat_word(t6, to_flag, t2);
      SRC_ARRAY:  dout = arr_rdata;
      default:    dout = '0;
    endcase
  end

  assign wr_data = prog_mask(wr_old, wr_new);
endmodule

// File: rtl/nor_status_chk.sv
module nor_status_chk
  import nor_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_act,
  input logic              rd_start,
  input logic              op_start,
  input logic              busy,
  input logic              ers_op,
  input logic              ers_susp,
  input logic              prot_on,
  input logic              sel_hit,
  input logic              timeout,
  input logic              reset_cmd,
  input logic              to_flag,
  input logic              t6,
  input logic              t2,
  input logic [DATA_W-1:0] arr_rdata,
  input logic [DATA_W-1:0] dout,
  input logic [DATA_W-1:0] wr_old,
  input logic [DATA_W-1:0] wr_data
);
  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act && !busy && !ers_susp && !prot_on && !to_flag |-> dout == arr_rdata);

  // R1
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |-> dout == '0);

  // R3
  tog_per_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start && busy && !op_start |=> t6 != $past(t6));

  // R3
  held_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act && !rd_start && !op_start |=> $stable(t6) && $stable(t2));

  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start && !rd_start |=> !t6 && !t2);

  // R5
  susp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ers_susp && !busy && !prot_on && !to_flag && !op_start |=> $stable(t6));

  // R7
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ers_op && sel_hit && rd_start) && !op_start |=> $stable(t2));

  // R9
  tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> to_flag);

  // R9
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag && !reset_cmd |=> to_flag);

  // R9
  tmo_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act && to_flag |-> dout[B_TMO]);

  // R10
  no_set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data & ~wr_old) == '0);
endmodule

bind nor_status_gen nor_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_act    (rd_act),
  .rd_start  (rd_start),
  .op_start  (op_start),
  .busy      (busy),
  .ers_op    (ers_op),
  .ers_susp  (ers_susp),
  .prot_on   (prot_on),
  .sel_hit   (sel_hit),
  .timeout   (timeout),
  .reset_cmd (reset_cmd),
  .to_flag   (to_flag),
  .t6        (t6),
  .t2        (t2),
  .arr_rdata (arr_rdata),
  .dout      (dout),
  .wr_old    (wr_old),
  .wr_data   (wr_data)
);

// File: tb/nor_status_gen_tb.sv
module nor_status_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_start = 1'b0, op_prog = 1'b0;
  logic [7:0] op_addr = 8'h00;
  logic       busy = 1'b0, ers_op = 1'b0, ers_susp = 1'b0;
  logic       timeout = 1'b0, reset_cmd = 1'b0;
  logic [3:0] ers_sel = 4'b0010;   // sector 1: 0x40..0x7F
  logic [3:0] prot    = 4'b1000;   // sector 3: 0xC0..0xFF
  logic [7:0] rd_addr = 8'h00;
  logic       ce_n = 1'b1, oe_n = 1'b1;
  logic [7:0] arr_rdata = 8'h00;
  logic [7:0] dout;
  logic [7:0] wr_old = 8'h00, wr_new = 8'h00;
  logic [7:0] wr_data;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;   // 250 MHz

  nor_status_gen u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_prog(op_prog),
    .op_addr(op_addr), .busy(busy), .ers_op(ers_op), .ers_susp(ers_susp),
    .timeout(timeout), .reset_cmd(reset_cmd), .ers_sel(ers_sel), .prot(prot),
    .rd_addr(rd_addr), .ce_n(ce_n), .oe_n(oe_n), .arr_rdata(arr_rdata),
    .dout(dout), .wr_old(wr_old), .wr_new(wr_new), .wr_data(wr_data)
  );

  // {busy, ers_op, ers_susp, rd_addr, arr_rdata, expected dout}
  localparam logic [26:0] VEC [13] = '{
    {1'b1, 1'b1, 1'b0, 8'h45, 8'h5A, 8'h44},  // R3 R7 first read
    {1'b1, 1'b1, 1'b0, 8'h45, 8'h5A, 8'h00},  // R3 R7
    {1'b1, 1'b1, 1'b0, 8'h10, 8'h5A, 8'h40},  // R7 unselected sector
    {1'b1, 1'b1, 1'b0, 8'h50, 8'h5A, 8'h04},  // R2 R7
    {1'b0, 1'b1, 1'b1, 8'h50, 8'h5A, 8'h00},  // R5 frozen bit 6
    {1'b0, 1'b1, 1'b1, 8'h20, 8'h3C, 8'h3C},  // R5 array
    {1'b0, 1'b1, 1'b1, 8'h60, 8'h3C, 8'h04},  // R5 R7 suspended
    {1'b1, 1'b1, 1'b1, 8'h20, 8'h99, 8'h44},  // R6
    {1'b1, 1'b1, 1'b1, 8'h48, 8'h99, 8'h00},  // R6
    {1'b0, 1'b1, 1'b1, 8'h20, 8'h77, 8'h77},  // R6 done
    {1'b0, 1'b1, 1'b1, 8'h41, 8'h77, 8'h04},  // R5 R7
    {1'b1, 1'b1, 1'b0, 8'h41, 8'h77, 8'h40},  // R3 resumed
    {1'b0, 1'b0, 1'b0, 8'h41, 8'hA5, 8'hA5}   // R1 idle
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one read access: strobes low for one cycle, then high for one
  task automatic rd(input logic [7:0] a, input logic [7:0] arr, input string req, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a; arr_rdata = arr; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk(req, dout, exp);
    oe_n = 1'b1;
  endtask

  task automatic start_op(input logic prog, input logic [7:0] a);
    @(negedge clk);
    op_start = 1'b1; op_prog = prog; op_addr = a;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic pulse_ctl(input logic tmo, input logic rcmd);
    @(negedge clk);
    timeout = tmo; reset_cmd = rcmd;
    @(negedge clk);
    timeout = 1'b0; reset_cmd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset bus", dout, 8'h00);
    rst_n = 1'b1;
    rd(8'h33, 8'hC7, "R1 idle read", 8'hC7);

    // erase flow through the vector table
    busy = 1'b1; ers_op = 1'b1;
    start_op(1'b0, 8'h40);
    for (int i = 0; i < 13; i++) begin
      busy = VEC[i][26]; ers_op = VEC[i][25]; ers_susp = VEC[i][24];
      rd(VEC[i][23:16], VEC[i][15:8], "R2-R7 vector", VEC[i][7:0]);
    end

    // R3: held strobes give one inversion; CE toggling opens a new access
    busy = 1'b1; ers_op = 1'b0;
    start_op(1'b1, 8'h05);
    @(negedge clk);
    rd_addr = 8'h45; arr_rdata = 8'h11; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); chk("R3 held first", dout, 8'h40);
    @(negedge clk); chk("R3 held second", dout, 8'h40);
    @(negedge clk); chk("R3 held third", dout, 8'h40);
    ce_n = 1'b1;
    @(negedge clk); chk("R1 ce high bus", dout, 8'h00);
    ce_n = 1'b0;
    @(negedge clk); chk("R3 R7 ce reopen", dout, 8'h00);
    oe_n = 1'b1;
    busy = 1'b0;

    // R4: operation start and read access on the same edge
    @(negedge clk);
    busy = 1'b1; ers_op = 1'b1; op_start = 1'b1; op_prog = 1'b0;
    rd_addr = 8'h45; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk("R4 collision", dout, 8'h44);
    op_start = 1'b0; oe_n = 1'b1;
    rd(8'h45, 8'h11, "R4 next read", 8'h00);
    busy = 1'b0; ers_op = 1'b0;

    // R9: timeout flag, reset command and their collision
    busy = 1'b1;
    start_op(1'b1, 8'h05);
    pulse_ctl(1'b1, 1'b0);
    rd(8'h05, 8'h11, "R9 flag busy", 8'h60);
    busy = 1'b0;
    rd(8'h05, 8'h11, "R9 flag held", 8'h20);
    pulse_ctl(1'b0, 1'b1);
    rd(8'h05, 8'h11, "R9 cleared", 8'h11);
    pulse_ctl(1'b1, 1'b1);
    rd(8'h05, 8'h11, "R9 set wins", 8'h60);
    pulse_ctl(1'b0, 1'b1);
    rd(8'h05, 8'h11, "R9 cleared again", 8'h11);

    // R8: protected program window, then array; unprotected gives none
    start_op(1'b1, 8'hC3);
    rd(8'hC3, 8'h5A, "R8 window first", 8'h40);
    repeat (100) @(negedge clk);
    rd(8'hC3, 8'h5A, "R8 window second", 8'h00);
    repeat (200) @(negedge clk);
    rd(8'hC3, 8'h5A, "R8 window over", 8'h5A);
    start_op(1'b1, 8'h05);
    rd(8'h05, 8'h5A, "R8 unprotected", 8'h5A);

    // R10: masking of write data
    @(negedge clk);
    wr_old = 8'hF0; wr_new = 8'h3C;
    #1 chk("R10 mask a", wr_data, 8'h30);
    wr_old = 8'h0F; wr_new = 8'hFF;
    #1 chk("R10 mask b", wr_data, 8'h0F);
    rd(8'h05, 8'h22, "R10 no timeout bit", 8'h22);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 1'b1, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule